// File: doc/BRIEF.md
# Escalating Restart Supervisor

This block decides how hard the system should try to recover when it is unhealthy. Three health indicators (a process died, an exception was taken inside a critical region, the system is overloaded) and an operator request input are its triggers. Each trigger leads to a single restart command whose type code says how much state the restart throws away. Together with each command it raises two wipe enables, one for temporary memory and one for permanent-allocation memory. The restart machinery reports back either success or failure.

Failures push an automatic recovery level up a fixed ladder: warm, then cold, then reload, then reboot from the primary stored image, then reboot from each older backup image in turn. The image index wraps back to the primary image, so the loop never ends. The block never waits for an operator. Every failure is followed straight away by the next command. When a success holds through a quiet period with no new trigger, all failure history is dropped and the ladder returns to warm.

Top module: `restart_escalator`

## Requirements
- R1: After reset no command is issued, `busy` is low, the automatic level is warm and the image index is 0.
- R2: When any health indicator is high while idle, a command is issued in the next cycle at the current automatic level, which starts at warm. `cmd_valid` is high for exactly one cycle.
- R3: When `usr_req` is high while idle, a command is issued in the next cycle with the requested type (`usr_kind` 0 = warm, 1 = cold, 2 = reload, 3 = reload). An operator request takes precedence over health indicators sampled in the same cycle.
- R4: `cmd_kind` encodes 0 = warm, 1 = cold, 2 = reload, 3 = reboot. `wipe_temp` is high together with every command. `wipe_perm` is high only with reload and reboot commands. Both wipe enables and `cmd_kind` are 0 when no command is issued.
- R5: Only one restart is outstanding at a time. `busy` rises with the command and stays high until a report arrives. Any trigger seen while busy counts as a failure of the outstanding restart. A failure report or trigger takes precedence over `rst_ok` in the same cycle.
- R6: A failure never ends the recovery. The next command is issued in the cycle after the failure is sampled.
- R7: After WARM_FAIL_LIM failed warm restarts, the automatic level becomes cold.
- R8: After COLD_FAIL_LIM failed cold restarts, the automatic level becomes reload.
- R9: A failed reload restart moves the automatic level to reboot with image index 0, the primary image.
- R10: A failed reboot advances the image index by one, wrapping from NUM_IMAGES-1 to 0. `cmd_image` is 0 on every command that is not a reboot.
- R11: After a success, QUIET_CYCLES idle cycles with no trigger clear both failure counters, the automatic level and the image index. A trigger that arrives earlier is served at the level still in force.
- R12: A failure never lowers the automatic level. A failed restart of a lower type that the operator requested leaves a higher level in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ind_proc_death | input | 1 | Health indicator: process death |
| ind_crit_exc | input | 1 | Health indicator: exception inside a critical region |
| ind_overload | input | 1 | Health indicator: system overload |
| usr_req | input | 1 | Operator restart request |
| usr_kind | input | 2 | Requested restart type |
| rst_ok | input | 1 | Outstanding restart succeeded |
| rst_fail | input | 1 | Outstanding restart failed |
| cmd_valid | output | 1 | One-cycle restart command strobe |
| cmd_kind | output | 2 | Restart type code |
| cmd_image | output | IMG_W | Image index used by a reboot |
| wipe_temp | output | 1 | Clear temporary memory for this restart |
| wipe_perm | output | 1 | Clear permanent-allocation memory for this restart |
| busy | output | 1 | A restart is being issued or is outstanding |

## Verification
Either failure counter or the ladder level can be wrong without any immediate sign. The error only shows on the command that follows the failure where the limit is reached, one cycle after that failure. The bench therefore drives full failure chains and compares the type, the image and the wipe enables on every clock. A quiet timer that expires early or late shows only on the first health-triggered command after a success, so triggers are placed both before and after the quiet period ends. A stuck sequencer state shows within one cycle as a wrong `busy` or a command strobe that is missing or repeated.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    K_WARM   = 2'd0,
    K_COLD   = 2'd1,
    K_RELOAD = 2'd2,
    K_REBOOT = 2'd3
  } rs_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_BUSY  = 2'd2
  } rs_state_e;

  // The more severe of two restart types.
  function automatic rs_kind_e max_kind(rs_kind_e a, rs_kind_e b);
    return (a > b) ? a : b;
  endfunction

  // Wipe enables {perm, temp} for a restart type.
  function automatic logic [1:0] wipe_mask(rs_kind_e k);
    return {(k == K_RELOAD) || (k == K_REBOOT), 1'b1};
  endfunction

  // Operator request code to restart type; code 3 asks for a reload.
  function automatic rs_kind_e req_to_kind(logic [1:0] code);
    return (code == 2'd3) ? K_RELOAD : rs_kind_e'(code);
  endfunction
endpackage

// File: rtl/rs_step_counter.sv
module rs_step_counter #(
  parameter int LIMIT = 3,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  input  logic clear,
  output logic hit
);
  logic [CW-1:0] cnt_q;

  assign hit = bump && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear || hit) cnt_q <= '0;
    else if (bump)              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/rs_fail_ladder.sv
module rs_fail_ladder import rs_pkg::*; #(
  parameter int WARM_LIM = 3,
  parameter int COLD_LIM = 3,
  parameter int NUM_IMG  = 4,
  parameter int IMG_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_stb,
  input  rs_kind_e         fail_kind,
  input  logic             clear_stb,
  output rs_kind_e         level,
  output logic [IMG_W-1:0] image
);
  logic [1:0] limit_hit;

  for (genvar g = 0; g < 2; g++) begin : g_step
    rs_step_counter #(.LIMIT((g == 0) ? WARM_LIM : COLD_LIM)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .bump  (fail_stb && (fail_kind == rs_kind_e'(g))),
      .clear (clear_stb),
      .hit   (limit_hit[g])
    );
  end

  function automatic logic [IMG_W-1:0] next_img(logic [IMG_W-1:0] cur);
    return (cur == IMG_W'(NUM_IMG - 1)) ? '0 : cur + IMG_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear_stb) begin
      level <= K_WARM;
      image <= '0;
    end else if (fail_stb) begin
      case (fail_kind)
        K_WARM:   if (limit_hit[0]) level <= max_kind(level, K_COLD);
        K_COLD:   if (limit_hit[1]) level <= max_kind(level, K_RELOAD);
        K_RELOAD: if (level != K_REBOOT) begin
                    level <= K_REBOOT;
                    image <= '0;
                  end
        default:  image <= next_img(image);
      endcase
    end
  end
endmodule

// File: rtl/rs_quiet_timer.sv
module rs_quiet_timer #(
  parameter int QUIET = 64,
  localparam int CW = $clog2(QUIET + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic expire
);
  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign expire = run_q && !start && !abort && (cnt_q == CW'(QUIET - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (abort || expire) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rs_cmd_seq.sv
module rs_cmd_seq import rs_pkg::*; #(
  parameter int IMG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             health_any,
  input  logic             req_valid,
  input  logic [1:0]       req_code,
  input  logic             done_ok,
  input  logic             done_fail,
  input  rs_kind_e         level,
  input  logic [IMG_W-1:0] image,
  output logic             cmd_valid,
  output rs_kind_e         cmd_kind,
  output logic [IMG_W-1:0] cmd_image,
  output logic             wipe_temp,
  output logic             wipe_perm,
  output logic             busy,
  output logic             fail_stb,
  output rs_kind_e         fail_kind,
  output logic             ok_stb,
  output logic             idle_trig
);
  rs_state_e state_q;
  logic      auto_q;
  rs_kind_e  kind_q;
  rs_kind_e  issue_kind;
  logic      trigger;

  assign trigger    = health_any || req_valid;
  assign issue_kind = auto_q ? level : kind_q;
  assign idle_trig  = (state_q == S_IDLE) && trigger;
  assign fail_stb   = (state_q == S_BUSY) && (done_fail || trigger);
  assign fail_kind  = kind_q;
  assign ok_stb     = (state_q == S_BUSY) && done_ok && !fail_stb;

  assign cmd_valid  = (state_q == S_ISSUE);
  assign cmd_kind   = cmd_valid ? issue_kind : K_WARM;
  assign cmd_image  = (cmd_valid && issue_kind == K_REBOOT) ? image : '0;
  assign {wipe_perm, wipe_temp} = cmd_valid ? wipe_mask(issue_kind) : 2'b00;
  assign busy       = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      auto_q  <= 1'b1;
      kind_q  <= K_WARM;
    end else begin
      case (state_q)
        S_IDLE: if (trigger) begin
          state_q <= S_ISSUE;
          auto_q  <= !req_valid;
          if (req_valid) kind_q <= req_to_kind(req_code);
        end
        S_ISSUE: begin
          kind_q  <= issue_kind;
          state_q <= S_BUSY;
        end
        S_BUSY: if (fail_stb) begin
          auto_q  <= 1'b1;
          state_q <= S_ISSUE;
        end else if (done_ok) begin
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/restart_escalator.sv
module restart_escalator import rs_pkg::*; #(
  parameter int WARM_FAIL_LIM = 3,
  parameter int COLD_FAIL_LIM = 3,
  parameter int NUM_IMAGES    = 4,
  parameter int QUIET_CYCLES  = 64,
  localparam int IMG_W = (NUM_IMAGES > 1) ? $clog2(NUM_IMAGES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ind_proc_death,
  input  logic             ind_crit_exc,
  input  logic             ind_overload,
  input  logic             usr_req,
  input  logic [1:0]       usr_kind,
  input  logic             rst_ok,
  input  logic             rst_fail,
  output logic             cmd_valid,
  output logic [1:0]       cmd_kind,
  output logic [IMG_W-1:0] cmd_image,
  output logic             wipe_temp,
  output logic             wipe_perm,
  output logic             busy
);
  logic             health_any;
  logic             fail_stb;
  rs_kind_e         fail_kind;
  logic             ok_stb;
  logic             idle_trig;
  logic             quiet_expire;
  rs_kind_e         lvl;
  logic [IMG_W-1:0] img;
  rs_kind_e         kind_e;

  assign health_any = ind_proc_death || ind_crit_exc || ind_overload;
  assign cmd_kind   = kind_e;

  rs_cmd_seq #(.IMG_W(IMG_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .health_any (health_any),
    .req_valid  (usr_req),
    .req_code   (usr_kind),
    .done_ok    (rst_ok),
    .done_fail  (rst_fail),
    .level      (lvl),
    .image      (img),
    .cmd_valid  (cmd_valid),
    .cmd_kind   (kind_e),
    .cmd_image  (cmd_image),
    .wipe_temp  (wipe_temp),
    .wipe_perm  (wipe_perm),
    .busy       (busy),
    .fail_stb   (fail_stb),
    .fail_kind  (fail_kind),
    .ok_stb     (ok_stb),
    .idle_trig  (idle_trig)
  );

  rs_fail_ladder #(
    .WARM_LIM (WARM_FAIL_LIM),
    .COLD_LIM (COLD_FAIL_LIM),
    .NUM_IMG  (NUM_IMAGES),
    .IMG_W    (IMG_W)
  ) u_ladder (
    .clk       (clk),
    .rst_n     (rst_n),
    .fail_stb  (fail_stb),
    .fail_kind (fail_kind),
    .clear_stb (quiet_expire),
    .level     (lvl),
    .image     (img)
  );

  rs_quiet_timer #(.QUIET(QUIET_CYCLES)) u_quiet (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (ok_stb),
    .abort  (idle_trig),
    .expire (quiet_expire)
  );
endmodule

// File: rtl/restart_escalator_chk.sv
module restart_escalator_chk import rs_pkg::*; #(
  parameter int IMG_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             health_any,
  input logic             usr_req,
  input logic [1:0]       usr_kind,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [IMG_W-1:0] cmd_image,
  input logic             wipe_temp,
  input logic             wipe_perm,
  input logic             busy,
  input logic             fail_stb,
  input logic             quiet_expire,
  input logic [1:0]       lvl,
  input logic [IMG_W-1:0] img
);
  p_strobe_then_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> busy && !cmd_valid);

  p_wipe_on_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> wipe_temp && (wipe_perm == (cmd_kind >= 2'd2)));

  p_no_wipe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !wipe_temp && !wipe_perm && (cmd_kind == 2'd0));

  p_never_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_stb |=> cmd_valid);

  p_level_monotone_r12: assert property (@(posedge clk) disable iff (!rst_n)
    fail_stb |=> lvl >= $past(lvl));

  p_image_reboot_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind != 2'd3) |-> (cmd_image == '0));

  p_quiet_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    quiet_expire |=> (lvl == 2'd0) && (img == '0));

  p_user_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_req && !busy) |=> cmd_valid && (cmd_kind == 2'(req_to_kind($past(usr_kind)))));

  p_health_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (health_any && !usr_req && !busy) |=> cmd_valid && (cmd_kind == $past(lvl)));
endmodule

bind restart_escalator restart_escalator_chk #(.IMG_W(IMG_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .health_any   (health_any),
  .usr_req      (usr_req),
  .usr_kind     (usr_kind),
  .cmd_valid    (cmd_valid),
  .cmd_kind     (cmd_kind),
  .cmd_image    (cmd_image),
  .wipe_temp    (wipe_temp),
  .wipe_perm    (wipe_perm),
  .busy         (busy),
  .fail_stb     (fail_stb),
  .quiet_expire (quiet_expire),
  .lvl          (lvl),
  .img          (img)
);

// File: tb/restart_escalator_tb_top.sv
module restart_escalator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WL = 3;
  localparam int CL = 3;
  localparam int NI = 4;
  localparam int QC = 64;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic death = 0, crit = 0, ovl = 0, ureq = 0, ok = 0, fail = 0;
  logic [1:0] ukind = 2'd0;
  logic cmd_valid, wipe_temp, wipe_perm, busy;
  logic [1:0] cmd_kind;
  logic [IW-1:0] cmd_image;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  restart_escalator #(
    .WARM_FAIL_LIM(WL), .COLD_FAIL_LIM(CL), .NUM_IMAGES(NI), .QUIET_CYCLES(QC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ind_proc_death(death), .ind_crit_exc(crit), .ind_overload(ovl),
    .usr_req(ureq), .usr_kind(ukind), .rst_ok(ok), .rst_fail(fail),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_image(cmd_image),
    .wipe_temp(wipe_temp), .wipe_perm(wipe_perm), .busy(busy)
  );

  // ---------------- behavioural reference model ----------------
  // phase: 0 waiting for trigger, 1 command cycle, 2 restart outstanding
  int m_phase, m_auto, m_req, m_issued, m_lvl, m_img, m_wf, m_cf, m_qrun, m_qcnt;

  task automatic model_fail(int k);
    if (k == 0) begin
      m_wf++;
      if (m_wf == WL) begin m_wf = 0; if (m_lvl < 1) m_lvl = 1; end
    end else if (k == 1) begin
      m_cf++;
      if (m_cf == CL) begin m_cf = 0; if (m_lvl < 2) m_lvl = 2; end
    end else if (k == 2) begin
      if (m_lvl < 3) begin m_lvl = 3; m_img = 0; end
    end else begin
      m_img = (m_img + 1) % NI;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_auto = 1; m_req = 0; m_issued = 0; m_lvl = 0;
      m_img = 0; m_wf = 0; m_cf = 0; m_qrun = 0; m_qcnt = 0;
    end else begin
      if (m_phase == 0) begin
        if (death || crit || ovl || ureq) begin
          m_qrun = 0;
          m_phase = 1;
          m_auto = ureq ? 0 : 1;
          if (ureq) m_req = (ukind == 2'd3) ? 2 : int'(ukind);
        end else if (m_qrun != 0) begin
          if (m_qcnt == QC - 1) begin
            m_qrun = 0; m_wf = 0; m_cf = 0; m_lvl = 0; m_img = 0;
          end else m_qcnt++;
        end
      end else if (m_phase == 1) begin
        m_issued = (m_auto != 0) ? m_lvl : m_req;
        m_phase = 2;
      end else begin
        if (fail || death || crit || ovl || ureq) begin
          model_fail(m_issued);
          m_auto = 1;
          m_phase = 1;
        end else if (ok) begin
          m_phase = 0; m_qrun = 1; m_qcnt = 0;
        end
      end
    end
  end

  function automatic int exp_kind();
    if (m_phase != 1) return 0;
    return (m_auto != 0) ? m_lvl : m_req;
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int k;
      k = exp_kind();
      cmp("R2", "cmd_valid", int'(cmd_valid), (m_phase == 1) ? 1 : 0);
      cmp("R4", "cmd_kind", int'(cmd_kind), k);
      cmp("R10", "cmd_image", int'(cmd_image), (m_phase == 1 && k == 3) ? m_img : 0);
      cmp("R4", "wipe_temp", int'(wipe_temp), (m_phase == 1) ? 1 : 0);
      cmp("R4", "wipe_perm", int'(wipe_perm), (m_phase == 1 && k >= 2) ? 1 : 0);
      cmp("R5", "busy", int'(busy), (m_phase != 0) ? 1 : 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic drive(bit d, bit c, bit o, bit u, logic [1:0] uk, bit s_ok, bit s_fail);
    @(negedge clk);
    death = d; crit = c; ovl = o; ureq = u; ukind = uk; ok = s_ok; fail = s_fail;
    @(negedge clk);
    death = 0; crit = 0; ovl = 0; ureq = 0; ukind = 2'd0; ok = 0; fail = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_cmd(string tag, int kind, int image);
    for (int i = 0; i < 20; i++) begin
      if (cmd_valid) break;
      @(negedge clk);
    end
    cmp(tag, "directed strobe", int'(cmd_valid), 1);
    cmp(tag, "directed kind", int'(cmd_kind), kind);
    cmp(tag, "directed image", int'(cmd_image), image);
    cmp(tag, "directed wipe_perm", int'(wipe_perm), (kind >= 2) ? 1 : 0);
  endtask

  task automatic report_ok();  drive(0, 0, 0, 0, 2'd0, 1, 0); endtask
  task automatic report_bad(); drive(0, 0, 0, 0, 2'd0, 0, 1); endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state
    cmp("R1", "reset cmd_valid", int'(cmd_valid), 0);
    cmp("R1", "reset busy", int'(busy), 0);
    cmp("R1", "reset wipe", int'(wipe_temp | wipe_perm), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R2, R4: health trigger gives a warm restart wiping temp only
    drive(1, 0, 0, 0, 2'd0, 0, 0);
    expect_cmd("R2", 0, 0);
    cmp("R4", "warm wipe_temp", int'(wipe_temp), 1);
    idle(5);
    cmp("R5", "busy held without report", int'(busy), 1);
    report_ok();
    idle(QC + 10);

    // R6, R7, R8, R9, R10: failure ladder
    drive(0, 1, 0, 0, 2'd0, 0, 0);
    expect_cmd("R2", 0, 0);
    report_bad(); expect_cmd("R6", 0, 0);
    report_bad(); expect_cmd("R6", 0, 0);
    report_bad(); expect_cmd("R7", 1, 0);
    report_bad(); expect_cmd("R7", 1, 0);
    report_bad(); expect_cmd("R7", 1, 0);
    report_bad(); expect_cmd("R8", 2, 0);
    report_bad(); expect_cmd("R9", 3, 0);
    report_bad(); expect_cmd("R10", 3, 1);
    report_bad(); expect_cmd("R10", 3, 2);
    report_bad(); expect_cmd("R10", 3, 3);
    report_bad(); expect_cmd("R10", 3, 0);
    report_ok();
    idle(5);

    // R12: operator warm restart failing keeps the reboot level
    drive(0, 0, 0, 1, 2'd0, 0, 0);
    expect_cmd("R3", 0, 0);
    report_bad(); expect_cmd("R12", 3, 0);
    report_ok();
    idle(5);

    // R11: trigger before quiet period ends keeps escalation
    drive(0, 0, 1, 0, 2'd0, 0, 0);
    expect_cmd("R11", 3, 0);
    report_ok();
    idle(QC + 10);
    drive(1, 0, 0, 0, 2'd0, 0, 0);
    expect_cmd("R11", 0, 0);
    report_ok();
    idle(QC + 10);

    // R3: operator request wins over health, and all request codes
    drive(1, 0, 0, 1, 2'd1, 0, 0);
    expect_cmd("R3", 1, 0);
    report_ok();
    drive(0, 0, 0, 1, 2'd2, 0, 0);
    expect_cmd("R3", 2, 0);
    report_ok();
    drive(0, 0, 0, 1, 2'd3, 0, 0);
    expect_cmd("R3", 2, 0);
    report_ok();
    idle(3);

    // R5: triggers while busy, and failure beating success
    drive(0, 0, 0, 1, 2'd0, 0, 0);
    expect_cmd("R3", 0, 0);
    drive(0, 1, 0, 0, 2'd0, 0, 0);
    expect_cmd("R5", 0, 0);
    drive(0, 0, 1, 0, 2'd0, 1, 0);
    expect_cmd("R5", 0, 0);
    report_ok();
    idle(10);
    cmp("R5", "idle after success", int'(busy), 0);

    finish_run();
  end
endmodule